// File: doc/BRIEF.md
# Sub-second Smooth Time Adjuster

This block shifts the phase of a running seconds clock by a fraction of a second, with no need to re-initialise the calendar. It keeps the synchronous sub-second down-counter, which is stepped by a prescaler tick, reloads from a programmable divide value, and emits one seconds-increment pulse per wrap. Software posts one adjustment request. The request carries a 15-bit hold-back amount and an optional one-second advance. The block applies it at the next prescaler tick. A pending flag is high from the write until that tick.

Adding the hold-back amount to the down-counter stretches the current second. The delay is therefore `delay/(divide+1)` seconds. The advance bit sends one extra seconds-increment pulse to the calendar on the applying tick. With both set, the net effect is an advance of `1 - delay/(divide+1)` seconds. A request is refused while the most significant bit of the sub-second count is set, because adding to it then could overflow. A refused request sets a sticky error flag.

Top module: `subsec_adjust_top`

## Requirements
- R1: After synchronous reset, `sub_cnt` equals `{1'b0, div_value}`, and `adj_pending`, `adj_error`, `sec_inc` and `sec_advance` are all 0.
- R2: In a cycle without `tick`, `sub_cnt` holds. On a `tick` with nothing to apply, `sub_cnt` decrements by one. At 0 it instead reloads `div_value`, and `sec_inc` is high for exactly the following cycle.
- R3: An accepted write (`req_wr` high) raises `adj_pending` in the next cycle. It stays high until the first later cycle in which `tick` is sampled, and it is low after that edge.
- R4: On the applying tick, `sub_cnt` becomes the normal next value (R2) plus `req_delay`. This holds the clock back by `req_delay` ticks.
- R5: If the stored request had `req_add1s = 1`, `sec_advance` is high for exactly the cycle after the applying tick. Otherwise it stays 0. The delay of R4 is applied either way.
- R6: A write while bit 15 of `sub_cnt` is 1 is ignored. `adj_pending` stays 0, `sub_cnt` keeps counting normally, and `adj_error` becomes 1 and stays 1 until reset.
- R7: A write while `adj_pending` is 1 is ignored and sets `adj_error`. The first stored request is the one applied.
- R8: A write sampled in the same cycle as a `tick` does not take part in that tick. It is applied at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler enable that steps the sub-second counter |
| div_value | input | 15 | Sub-second reload (divide minus one) |
| req_wr | input | 1 | Adjustment write strobe |
| req_delay | input | 15 | Hold-back amount in ticks |
| req_add1s | input | 1 | Request a one-second advance |
| sub_cnt | output | 16 | Sub-second down-counter |
| sec_inc | output | 1 | Seconds increment from a counter wrap |
| sec_advance | output | 1 | Extra seconds increment from an advance |
| adj_pending | output | 1 | Request stored and not yet applied |
| adj_error | output | 1 | Sticky flag for a refused request |

## Verification
Every result is registered once. The counter value, `sec_inc`, `sec_advance` and the cleared pending flag appear one cycle after the edge that samples `tick`. The raised pending flag and the error flag appear one cycle after the edge that samples `req_wr`. The bench drives inputs on the falling edge and holds them for exactly one rising edge. It reads the outputs at the next falling edge, which is the only cycle in which the one-cycle pulses are visible. Each vector starts from reset, so its expected counter value follows from the tick count and the R2/R4 arithmetic alone.

// File: rtl/subsec_adjust_pkg.sv
package subsec_adjust_pkg;
  localparam int DELAY_W = 15;
  localparam int CNT_W   = DELAY_W + 1;

  typedef struct packed {
    logic               add1s;
    logic [DELAY_W-1:0] delay;
  } adj_req_t;
endpackage

// File: rtl/subsec_adj_request.sv
module subsec_adj_request
  import subsec_adjust_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               req_wr,
  input  logic [DELAY_W-1:0] req_delay,
  input  logic               req_add1s,
  input  logic               cnt_msb,
  output logic               pending,
  output logic               err,
  output logic               apply,
  output adj_req_t           held
);
  logic accept;

  assign accept = req_wr && !pending && !cnt_msb;
  assign apply  = pending && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      err     <= 1'b0;
      held    <= '0;
    end else begin
      if (apply)
        pending <= 1'b0;
      if (accept) begin
        pending     <= 1'b1;
        held.delay  <= req_delay;
        held.add1s  <= req_add1s;
      end
      if (req_wr && !accept)
        err <= 1'b1;
    end
  end

  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
    (pending && tick) |=> !pending); // R3
  AST_OVF_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (req_wr && cnt_msb && !pending) |=> (!pending && err)); // R6
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (req_wr && pending && !tick) |=> (pending && err && $stable(held))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R6
endmodule

// File: rtl/subsec_counter.sv
module subsec_counter
  import subsec_adjust_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [DELAY_W-1:0] div_value,
  input  logic               apply,
  input  adj_req_t           held,
  output logic [CNT_W-1:0]   cnt,
  output logic               wrap_pulse,
  output logic               adv_pulse
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign base    = at_zero ? {1'b0, div_value} : cnt - 1'b1;
  assign nxt     = apply ? base + {1'b0, held.delay} : base;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= {1'b0, div_value};
      wrap_pulse <= 1'b0;
      adv_pulse  <= 1'b0;
    end else begin
      wrap_pulse <= tick && at_zero;
      adv_pulse  <= apply && held.add1s;
      if (tick)
        cnt <= nxt;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    apply |-> !cnt[CNT_W-1]); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse || $past(tick)); // R2
endmodule

// File: rtl/subsec_adjust_top.sv
module subsec_adjust_top
  import subsec_adjust_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [DELAY_W-1:0] div_value,
  input  logic               req_wr,
  input  logic [DELAY_W-1:0] req_delay,
  input  logic               req_add1s,
  output logic [CNT_W-1:0]   sub_cnt,
  output logic               sec_inc,
  output logic               sec_advance,
  output logic               adj_pending,
  output logic               adj_error
);
  logic     apply;
  adj_req_t held;

  subsec_adj_request u_req (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req_wr    (req_wr),
    .req_delay (req_delay),
    .req_add1s (req_add1s),
    .cnt_msb   (sub_cnt[CNT_W-1]),
    .pending   (adj_pending),
    .err       (adj_error),
    .apply     (apply),
    .held      (held)
  );

  subsec_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .div_value  (div_value),
    .apply      (apply),
    .held       (held),
    .cnt        (sub_cnt),
    .wrap_pulse (sec_inc),
    .adv_pulse  (sec_advance)
  );

  AST_ADV_AFTER_APPLY: assert property (@(posedge clk) disable iff (rst)
    sec_advance |-> $past(tick && adj_pending)); // R5
  AST_ROLL_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !adj_pending && sub_cnt == '0) |=> (sec_inc && sub_cnt == {1'b0, div_value})); // R2
endmodule

// File: tb/subsec_adjust_tb.sv
`timescale 1ns/1ps
module subsec_adjust_top_tb_top;
  localparam int DW = 15;
  localparam int CW = 16;
  localparam logic [DW-1:0] DIV = 15'd9;
  // {ticks(8), delay(15), add1s(1), exp_cnt(16), exp_sec(1), exp_adv(1)}
  localparam int NV = 5;
  localparam logic [41:0] VEC [NV] = '{
    {8'd3, 15'd5,     1'b0, 16'd10,    1'b0, 1'b0},
    {8'd9, 15'd2,     1'b0, 16'd11,    1'b1, 1'b0},
    {8'd0, 15'd0,     1'b1, 16'd8,     1'b0, 1'b1},
    {8'd5, 15'd7,     1'b1, 16'd10,    1'b0, 1'b1},
    {8'd2, 15'h7FFF,  1'b0, 16'h8005,  1'b0, 1'b0}
  };

  logic clk = 0, rst = 1, tick = 0, req_wr = 0, req_add1s = 0;
  logic [DW-1:0] req_delay = '0;
  logic [CW-1:0] sub_cnt;
  logic sec_inc, sec_advance, adj_pending, adj_error;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  subsec_adjust_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .div_value(DIV),
    .req_wr(req_wr), .req_delay(req_delay), .req_add1s(req_add1s),
    .sub_cnt(sub_cnt), .sec_inc(sec_inc), .sec_advance(sec_advance),
    .adj_pending(adj_pending), .adj_error(adj_error)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1; tick = 0; req_wr = 0;
    @(negedge clk);
    @(negedge clk) rst = 0;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic do_req(logic [DW-1:0] d, logic a);
    req_wr = 1; req_delay = d; req_add1s = a;
    @(negedge clk) req_wr = 0;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt", sub_cnt, DIV);
    chk("R1 pend", adj_pending, 0);
    chk("R1 err", adj_error, 0);
    chk("R1 pulses", {sec_inc, sec_advance}, 0);

    // Vector walk: R4 R5 and R3
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int t = 0; t < int'(VEC[v][41:34]); t++) do_tick();
      do_req(VEC[v][33:19], VEC[v][18]);
      chk("R3 pend set", adj_pending, 1);
      do_tick();
      chk("R4 cnt", sub_cnt, VEC[v][17:2]);
      chk("R2 sec", sec_inc, VEC[v][1]);
      chk("R5 adv", sec_advance, VEC[v][0]);
      chk("R3 pend clr", adj_pending, 0);
      @(negedge clk);
      chk("R5 adv one cycle", sec_advance, 0);
    end

    // R6 overflow refusal (count now 0x8005 minus nothing)
    do_req(15'd1, 1'b1);
    chk("R6 pend", adj_pending, 0);
    chk("R6 err", adj_error, 1);
    do_tick();
    chk("R6 cnt", sub_cnt, 16'h8004);
    chk("R6 adv", sec_advance, 0);
    chk("R6 sticky", adj_error, 1);

    // R2 idle hold and rollover
    do_reset();
    repeat (3) @(negedge clk);
    chk("R2 hold", sub_cnt, DIV);
    for (int t = 0; t < 9; t++) do_tick();
    chk("R2 zero", sub_cnt, 0);
    do_tick();
    chk("R2 reload", sub_cnt, DIV);
    chk("R2 sec", sec_inc, 1);
    @(negedge clk);
    chk("R2 sec one cycle", sec_inc, 0);

    // R7 write while pending
    do_reset();
    do_req(15'd3, 1'b0);
    do_req(15'd4, 1'b1);
    chk("R7 err", adj_error, 1);
    chk("R7 pend", adj_pending, 1);
    do_tick();
    chk("R7 cnt", sub_cnt, 11);
    chk("R7 adv", sec_advance, 0);

    // R8 write and tick together
    do_reset();
    tick = 1;
    do_req(15'd2, 1'b0);
    tick = 0;
    chk("R8 cnt", sub_cnt, 8);
    chk("R8 pend", adj_pending, 1);
    do_tick();
    chk("R8 applied", sub_cnt, 9);
    chk("R8 err", adj_error, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule